// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a small byte-wide register bank that sits behind a plain write/read port: an 8-bit address, 8-bit write data with a write strobe, and combinational read data. A few of its registers hold settings that should not change by accident. Writes to them are gated by two unlock levels, configuration and test. Software opens a level by writing a specific pair of codes, one after the other, to a key register.

Every register applies its own write rule. The boot register takes writes only while the configuration level is open, and it always keeps its guard field (bits 6:4). Each of the three dedicated registers has a low field that is always writable; its guard field becomes writable only while the test level is open. The three group registers accept writes to their upper nibble at any time and never change their lower nibble.

The unlock level is held in a four-state machine. The states are LK_NONE (nothing open), LK_CFG (configuration open), LK_TST (test open) and LK_BOTH (both open). A key write is the only event that moves it. On a key write the next state is normally LK_NONE. The exceptions are the three code pairs: arm 0xC0 then open 0x0C leads to LK_CFG, arm 0x0E then open 0xE0 leads to LK_TST, and arm 0xCE then open 0xEC leads to LK_BOTH. Without a key write the state holds.

Top module: `kcb_bank`

## Requirements
- R1: After reset, both unlock flags are 0 and the registers read key 0x10 = 0x00, boot 0x11 = 0x28, dedicated 0x20/0x21/0x22 = 0x21/0x12/0x34, and group 0x30/0x31/0x32 = 0x05/0x03/0x0A. A reset applied after an unlock restores all of these values.
- R2: Any write to the key register (0x10) first closes both levels. The written byte is then stored and reads back from 0x10.
- R3: Writing 0x0C to the key register while it holds 0xC0 opens the configuration level only (cfg_unlocked=1, tst_unlocked=0).
- R4: Writing 0xE0 to the key register while it holds 0x0E opens the test level only (tst_unlocked=1, cfg_unlocked=0).
- R5: Writing 0xEC to the key register while it holds 0xCE opens both levels.
- R6: The code pair must be written in order (arm, then open) as consecutive key writes. The reverse order opens nothing, and repeating the open code closes the level again. Writes to other addresses between the two key writes do not disturb the stored key.
- R7: A write to the boot register (0x11) while the configuration level is closed leaves it unchanged.
- R8: A boot write accepted while the configuration level is open yields (old & 0x70) | (data & 0x8F).
- R9: With the test level closed, a dedicated-register write yields (old & 0x70) | (data & low). The low field is 0x07 at 0x20, 0x03 at 0x21 and 0x0F at 0x22.
- R10: With the test level open, a dedicated-register write yields data & (0x70 | low).
- R11: A group-register write (0x30..0x32) yields (old & 0x0F) | (data & 0xF0), whatever the unlock level.
- R12: Writes to unmapped addresses change nothing, and reads from them return 0x00.
- R13: Opening only the configuration level does not widen the dedicated registers. They keep the R9 rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address for both read and write |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| cfg_unlocked | output | 1 | Configuration level is open |
| tst_unlocked | output | 1 | Test level is open |

## Verification
The hardest case to reach is a dedicated register that has been widened under the test level while the configuration level stays closed. A second hard case is a code pair that is split by unrelated writes. In both, the outcome depends on the stored key from an earlier write, not on the current one. The stimulus therefore builds the key history on purpose: it writes reversed pairs, writes repeated open codes, and inserts a group-register write between an arm code and its open code. It then probes every masked register under each unlock level, including a configuration-only unlock that must not widen the dedicated guard field.

// File: rtl/kcb_pkg.sv
package kcb_pkg;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_CFG  = 2'd1,
        LK_TST  = 2'd2,
        LK_BOTH = 2'd3
    } lock_e;

    localparam logic [7:0] A_KEY      = 8'h10;
    localparam logic [7:0] A_BOOT     = 8'h11;
    localparam logic [7:0] A_DED_BASE = 8'h20;
    localparam logic [7:0] A_GRP_BASE = 8'h30;

    localparam logic [7:0] ARM_CFG   = 8'hC0;
    localparam logic [7:0] OPEN_CFG  = 8'h0C;
    localparam logic [7:0] ARM_TST   = 8'h0E;
    localparam logic [7:0] OPEN_TST  = 8'hE0;
    localparam logic [7:0] ARM_BOTH  = 8'hCE;
    localparam logic [7:0] OPEN_BOTH = 8'hEC;

    localparam logic [7:0] GUARD_FIELD = 8'h70;
    localparam logic [7:0] BOOT_MASK   = 8'h8F;
    localparam logic [7:0] BOOT_RST    = 8'h28;
    localparam logic [7:0] GRP_MASK    = 8'hF0;

    // width of the always-writable low field of dedicated register i
    function automatic int ded_low_bits(input int i);
        case (i)
            0:       return 3;
            1:       return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] ded_low_mask(input int i);
        return 8'((1 << ded_low_bits(i)) - 1);
    endfunction

    function automatic logic [7:0] ded_reset(input int i);
        case (i)
            0:       return 8'h21;
            1:       return 8'h12;
            default: return 8'h34;
        endcase
    endfunction

    function automatic logic [7:0] grp_reset(input int i);
        case (i)
            0:       return 8'h05;
            1:       return 8'h03;
            default: return 8'h0A;
        endcase
    endfunction

endpackage

// File: rtl/kcb_key_ctrl.sv
module kcb_key_ctrl
    import kcb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_we,
    input  logic [DW-1:0] key_wdata,
    output logic [DW-1:0] key_q,
    output logic          cfg_open,
    output logic          tst_open
);

    lock_e state_q, state_d;

    // stored key: always takes the new byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_q <= '0;
        else if (key_we)
            key_q <= key_wdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LK_NONE;
        else
            state_q <= state_d;
    end

    // transitions: any key write closes, matching pair reopens
    always_comb begin
        state_d = state_q;
        if (key_we) begin
            state_d = LK_NONE;
            unique case (key_wdata)
                DW'(OPEN_CFG):  if (key_q == DW'(ARM_CFG))  state_d = LK_CFG;
                DW'(OPEN_TST):  if (key_q == DW'(ARM_TST))  state_d = LK_TST;
                DW'(OPEN_BOTH): if (key_q == DW'(ARM_BOTH)) state_d = LK_BOTH;
                default:        state_d = LK_NONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_NONE: begin cfg_open = 1'b0; tst_open = 1'b0; end
            LK_CFG:  begin cfg_open = 1'b1; tst_open = 1'b0; end
            LK_TST:  begin cfg_open = 1'b0; tst_open = 1'b1; end
            LK_BOTH: begin cfg_open = 1'b1; tst_open = 1'b1; end
            default: begin cfg_open = 1'b0; tst_open = 1'b0; end
        endcase
    end

endmodule

// File: rtl/kcb_field_reg.sv
module kcb_field_reg #(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] RST    = '0,
    parameter logic [DW-1:0] KEEP_N = '0,
    parameter logic [DW-1:0] MASK_N = '1,
    parameter logic [DW-1:0] KEEP_W = '0,
    parameter logic [DW-1:0] MASK_W = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          allow,
    input  logic          widen,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    logic [DW-1:0] keep, mask, nxt;

    always_comb begin
        keep = widen ? KEEP_W : KEEP_N;
        mask = widen ? MASK_W : MASK_N;
        nxt  = (q & keep) | (wdata & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST;
        else if (we && allow)
            q <= nxt;
    end

endmodule

// File: rtl/kcb_bank.sv
module kcb_bank
    import kcb_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int N_DED = 3,
    parameter int N_GRP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          cfg_unlocked,
    output logic          tst_unlocked
);

    localparam logic [AW-1:0] KEY_A  = AW'(A_KEY);
    localparam logic [AW-1:0] BOOT_A = AW'(A_BOOT);
    localparam logic [AW-1:0] DED_A  = AW'(A_DED_BASE);
    localparam logic [AW-1:0] GRP_A  = AW'(A_GRP_BASE);

    logic [DW-1:0] key_q, boot_q;
    logic [DW-1:0] ded_q [N_DED];
    logic [DW-1:0] grp_q [N_GRP];
    logic          cfg_open, tst_open;

    kcb_key_ctrl #(.DW(DW)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_we    (wr_en && (addr == KEY_A)),
        .key_wdata (wr_data),
        .key_q     (key_q),
        .cfg_open  (cfg_open),
        .tst_open  (tst_open)
    );

    kcb_field_reg #(
        .DW(DW), .RST(DW'(BOOT_RST)),
        .KEEP_N(DW'(GUARD_FIELD)), .MASK_N(DW'(BOOT_MASK)),
        .KEEP_W(DW'(GUARD_FIELD)), .MASK_W(DW'(BOOT_MASK))
    ) u_boot (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && (addr == BOOT_A)), .allow(cfg_open), .widen(1'b0),
        .wdata(wr_data), .q(boot_q)
    );

    for (genvar i = 0; i < N_DED; i++) begin : g_ded
        localparam logic [DW-1:0] LOW = DW'(ded_low_mask(i));
        kcb_field_reg #(
            .DW(DW), .RST(DW'(ded_reset(i))),
            .KEEP_N(DW'(GUARD_FIELD)), .MASK_N(LOW),
            .KEEP_W('0),               .MASK_W(DW'(GUARD_FIELD) | LOW)
        ) u_ded (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && (addr == DED_A + AW'(i))), .allow(1'b1), .widen(tst_open),
            .wdata(wr_data), .q(ded_q[i])
        );
    end

    for (genvar i = 0; i < N_GRP; i++) begin : g_grp
        kcb_field_reg #(
            .DW(DW), .RST(DW'(grp_reset(i))),
            .KEEP_N(~DW'(GRP_MASK)), .MASK_N(DW'(GRP_MASK)),
            .KEEP_W(~DW'(GRP_MASK)), .MASK_W(DW'(GRP_MASK))
        ) u_grp (
            .clk(clk), .rst_n(rst_n),
            .we(wr_en && (addr == GRP_A + AW'(i))), .allow(1'b1), .widen(1'b0),
            .wdata(wr_data), .q(grp_q[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (addr == KEY_A)  rd_data = key_q;
        if (addr == BOOT_A) rd_data = boot_q;
        for (int i = 0; i < N_DED; i++)
            if (addr == DED_A + AW'(i)) rd_data = ded_q[i];
        for (int i = 0; i < N_GRP; i++)
            if (addr == GRP_A + AW'(i)) rd_data = grp_q[i];
    end

    assign cfg_unlocked = cfg_open;
    assign tst_unlocked = tst_open;

endmodule

// File: rtl/kcb_bank_chk.sv
module kcb_bank_chk
    import kcb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       cfg_unlocked,
    input logic       tst_unlocked
);

    // R2: a key write that is not an open code leaves both levels closed
    a_r2_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wr_data != OPEN_CFG && wr_data != OPEN_TST
         && wr_data != OPEN_BOTH) |=> (!cfg_unlocked && !tst_unlocked));

    // R2: the key byte just written reads back
    a_r2_key_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_KEY && $past(wr_en && addr == A_KEY)) |-> rd_data == $past(wr_data));

    // R3: the configuration open code never opens the test level
    a_r3_cfg_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wr_data == OPEN_CFG) |=> !tst_unlocked);

    // R4: the test open code never opens the configuration level
    a_r4_tst_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wr_data == OPEN_TST) |=> !cfg_unlocked);

    // R7: the boot register does not move while configuration is closed
    a_r7_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_BOOT && $past(addr == A_BOOT) && !$past(cfg_unlocked))
        |-> rd_data == $past(rd_data));

    // R9: the dedicated guard field holds while test is closed
    a_r9_ded_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_DED_BASE && $past(addr == A_DED_BASE) && !$past(tst_unlocked))
        |-> rd_data[6:4] == $past(rd_data[6:4]));

    // R11: the group lower nibble never changes
    a_r11_grp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_GRP_BASE && $past(addr == A_GRP_BASE))
        |-> rd_data[3:0] == $past(rd_data[3:0]));

    // R12: unmapped reads return zero
    a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h40 || addr == 8'hFF) |-> rd_data == 8'h00);

endmodule

bind kcb_bank kcb_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_unlocked(cfg_unlocked), .tst_unlocked(tst_unlocked)
);

// File: tb/sim_kcb_bank.sv
module sim_kcb_bank;

    typedef struct {
        bit       is_flag;
        logic [7:0] exp;
        string    tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cfg_unlocked, tst_unlocked;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    kcb_bank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .cfg_unlocked(cfg_unlocked), .tst_unlocked(tst_unlocked)
    );

    // monitor: sample 3 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = it.is_flag ? {6'b0, tst_unlocked, cfg_unlocked} : rd_data;
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.is_flag = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // expected flags as {tst, cfg}
    task automatic fl(input logic [1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.is_flag = 1'b1; it.exp = {6'b0, e}; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        fl(2'b00, "R1 flags");
        rd(8'h10, 8'h00, "R1 key");
        rd(8'h11, 8'h28, "R1 boot");
        rd(8'h20, 8'h21, "R1 ded0");
        rd(8'h21, 8'h12, "R1 ded1");
        rd(8'h22, 8'h34, "R1 ded2");
        rd(8'h30, 8'h05, "R1 grp0");
        rd(8'h31, 8'h03, "R1 grp1");
        rd(8'h32, 8'h0A, "R1 grp2");

        wr(8'h40, 8'hFF);
        rd(8'h40, 8'h00, "R12 unmapped read");
        rd(8'h11, 8'h28, "R12 no alias");

        wr(8'h11, 8'hFF);
        rd(8'h11, 8'h28, "R7 boot locked");

        wr(8'h30, 8'hA7);
        rd(8'h30, 8'hA5, "R11 grp0");
        wr(8'h32, 8'h3C);
        rd(8'h32, 8'h3A, "R11 grp2");

        wr(8'h20, 8'hFF);
        rd(8'h20, 8'h27, "R9 ded0");
        wr(8'h21, 8'hFF);
        rd(8'h21, 8'h13, "R9 ded1");
        wr(8'h22, 8'hFF);
        rd(8'h22, 8'h3F, "R9 ded2");

        wr(8'h10, 8'hC0);
        fl(2'b00, "R3 arm only");
        rd(8'h10, 8'hC0, "R2 key stored");
        wr(8'h10, 8'h0C);
        fl(2'b01, "R3 cfg open");

        wr(8'h11, 8'hFF);
        rd(8'h11, 8'hAF, "R8 boot write");
        wr(8'h11, 8'h00);
        rd(8'h11, 8'h20, "R8 boot guard");

        wr(8'h20, 8'h55);
        rd(8'h20, 8'h25, "R13 cfg no widen");

        wr(8'h10, 8'h33);
        fl(2'b00, "R2 key closes");
        rd(8'h10, 8'h33, "R2 key readback");
        wr(8'h11, 8'h0F);
        rd(8'h11, 8'h20, "R7 relocked");

        wr(8'h10, 8'h0C);
        wr(8'h10, 8'hC0);
        fl(2'b00, "R6 reversed pair");
        wr(8'h31, 8'h50);
        rd(8'h31, 8'h53, "R11 grp1");
        wr(8'h10, 8'h0C);
        fl(2'b01, "R6 pair split by other write");
        wr(8'h10, 8'h0C);
        fl(2'b00, "R6 repeated open");

        wr(8'h10, 8'h0E);
        wr(8'h10, 8'hE0);
        fl(2'b10, "R4 tst open");
        wr(8'h20, 8'hFF);
        rd(8'h20, 8'h77, "R10 ded0");
        wr(8'h21, 8'h5A);
        rd(8'h21, 8'h52, "R10 ded1");
        wr(8'h11, 8'h00);
        rd(8'h11, 8'h20, "R4 boot still locked");

        wr(8'h10, 8'hCE);
        wr(8'h10, 8'hEC);
        fl(2'b11, "R5 both open");
        wr(8'h22, 8'h8B);
        rd(8'h22, 8'h0B, "R10 ded2");
        wr(8'h11, 8'h8F);
        rd(8'h11, 8'hAF, "R5 boot open");

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fl(2'b00, "R1 reset flags");
        rd(8'h10, 8'h00, "R1 reset key");
        rd(8'h11, 8'h28, "R1 reset boot");
        rd(8'h22, 8'h34, "R1 reset ded2");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule